// File: doc/BRIEF.md
# Shared Clock Stuck-Low Watchdog

This block watches a wired-AND coordination line shared by several controllers. Any device may pull the line low, and the line rests high when nobody does. The block measures how long the line stays low without a break, counting in microsecond ticks. When that low time goes past a limit (64 µs by default), the block treats the line as stuck. It then pulls the line low itself for a fixed hold period (120 ms by default). This stretches the fault into a long low event that every other device on the line sees as at least a minimum retry delay, so all of them restart together.

On detection the block also sets a sticky status bit, which stays set until a clear pulse arrives. The line level is synchronized with flip-flops before it is measured. Low time that the block causes with its own hold drive never starts a new detection. Measurement starts again only after the line has been released and seen high.

Top module: `shclk_stuck_watchdog`

## Requirements
- R1: After reset, `pull_low` is 0 and `stuck_flag` is 0.
- R2: The line passes through a SYNC_STAGES-flop synchronizer (2 by default). A fault is detected on the tick that finds the line low for more than LOW_LIMIT_US consecutive ticks. With a tick every cycle, a low of LOW_LIMIT_US or fewer clock cycles causes no fault, and `pull_low` rises on the LOW_LIMIT_US+3rd clock edge after the line goes low.
- R3: Any sample of the line seen high resets the low-time count. Two lows of LOW_LIMIT_US cycles each, separated by one high cycle, cause no fault.
- R4: After detection, `pull_low` is 1 for exactly HOLD_US ticks, then returns to 0.
- R5: Detection sets `stuck_flag` to 1. It stays 1 through the hold and afterwards, until a clear pulse arrives.
- R6: A one-cycle pulse on `clr_flag` drops `stuck_flag` to 0 on the next edge, unless a detection happens in the same cycle, in which case the set wins. The clear has no effect on `pull_low`.
- R7: Neither the block's own hold drive nor a line still held low after release triggers a new detection. Measurement resumes only once the synchronized line is seen high.
- R8: The low-time count advances only on cycles where `tick_1us` is 1. A line held low with no ticks never causes a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle pulse once per microsecond |
| line_in | input | 1 | Raw level of the shared line (1 = high) |
| clr_flag | input | 1 | One-cycle pulse that clears the sticky status bit |
| pull_low | output | 1 | Open-drain enable; 1 means drive the line low |
| stuck_flag | output | 1 | Sticky stuck-low status bit |

## Verification
The assertions assume that `tick_1us` never stays high when the count has reached its limit in a way that would need saturation beyond it. They also assume that `line_in` reflects the block's own `pull_low` through the wired-AND, so the line reads low during the hold. The bench keeps to both assumptions. It models the line as the AND of its own external pull and the design's `pull_low`, and drives the tick either every cycle or not at all, so every tick position is known. Clear pulses are always single cycles, and they are applied away from the cycle of a detection, except where the order of clear and set is itself the point of the check.

// File: rtl/shclk_wd_pkg.sv
package shclk_wd_pkg;

   typedef enum logic [1:0] {
      ST_WATCH     = 2'd0,
      ST_HOLD      = 2'd1,
      ST_WAIT_HIGH = 2'd2
   } wd_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      cnt_width = (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/shclk_wd_sync.sv
module shclk_wd_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
               else        chain_q <= d_in;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
               else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
         end
         assign q_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/shclk_wd_lowtimer.sv
module shclk_wd_lowtimer #(
   parameter int unsigned LIMIT = 64,
   parameter int unsigned CW    = shclk_wd_pkg::cnt_width(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line_s,
   input  logic          arm,
   output logic [CW-1:0] low_cnt,
   output logic          detect
);

   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic at_limit;
   assign at_limit = (low_cnt == LIM_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!arm || line_s) begin
         low_cnt <= '0;
      end else if (tick && !at_limit) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign detect = arm & ~line_s & tick & at_limit;

endmodule

// File: rtl/shclk_wd_hold.sv
module shclk_wd_hold #(
   parameter int unsigned HOLD = 120000,
   parameter int unsigned CW   = shclk_wd_pkg::cnt_width(HOLD - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line_s,
   input  logic          detect,
   output logic          arm,
   output logic          pull_low,
   output logic [CW-1:0] hold_cnt
);
   import shclk_wd_pkg::*;

   localparam logic [CW-1:0] LAST_V = CW'(HOLD - 1);

   wd_state_e state_q, state_d;
   logic [CW-1:0] hold_d;

   always_comb begin
      state_d = state_q;
      hold_d  = hold_cnt;
      case (state_q)
         ST_WATCH: begin
            hold_d = '0;
            if (detect) state_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (tick) begin
               if (hold_cnt == LAST_V) begin
                  state_d = ST_WAIT_HIGH;
                  hold_d  = '0;
               end else begin
                  hold_d = hold_cnt + 1'b1;
               end
            end
         end
         ST_WAIT_HIGH: begin
            hold_d = '0;
            if (line_s) state_d = ST_WATCH;
         end
         default: begin
            state_d = ST_WATCH;
            hold_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_WATCH;
         hold_cnt <= '0;
      end else begin
         state_q  <= state_d;
         hold_cnt <= hold_d;
      end
   end

   assign arm      = (state_q == ST_WATCH);
   assign pull_low = (state_q == ST_HOLD);

endmodule

// File: rtl/shclk_wd_flag.sv
module shclk_wd_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_q
);

   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_priority
         assign flag_d = set_i | (flag_q & ~clr_i);
      end else begin : g_clr_priority
         assign flag_d = ~clr_i & (set_i | flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

endmodule

// File: rtl/shclk_stuck_watchdog.sv
module shclk_stuck_watchdog #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned LOW_LIMIT_US = 64,
   parameter int unsigned HOLD_US      = 120000,
   parameter bit          SET_WINS     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1us,
   input  logic line_in,
   input  logic clr_flag,
   output logic pull_low,
   output logic stuck_flag
);

   localparam int unsigned LCW = shclk_wd_pkg::cnt_width(LOW_LIMIT_US);
   localparam int unsigned HCW = shclk_wd_pkg::cnt_width(HOLD_US - 1);

   generate
      if (LOW_LIMIT_US < 1) begin : g_bad_limit
         $error("LOW_LIMIT_US must be at least 1");
      end
      if (HOLD_US < 2) begin : g_bad_hold
         $error("HOLD_US must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 4 or fewer");
      end
   endgenerate

   logic           line_s;
   logic           arm;
   logic           detect;
   logic [LCW-1:0] low_cnt;
   logic [HCW-1:0] hold_cnt;

   shclk_wd_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (line_in),
      .q_out (line_s)
   );

   shclk_wd_lowtimer #(
      .LIMIT (LOW_LIMIT_US),
      .CW    (LCW)
   ) lowtmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1us),
      .line_s  (line_s),
      .arm     (arm),
      .low_cnt (low_cnt),
      .detect  (detect)
   );

   shclk_wd_hold #(
      .HOLD (HOLD_US),
      .CW   (HCW)
   ) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_1us),
      .line_s   (line_s),
      .detect   (detect),
      .arm      (arm),
      .pull_low (pull_low),
      .hold_cnt (hold_cnt)
   );

   shclk_wd_flag #(
      .SET_WINS (SET_WINS)
   ) flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (detect),
      .clr_i  (clr_flag),
      .flag_q (stuck_flag)
   );

endmodule

// File: rtl/shclk_wd_checker.sv
module shclk_wd_checker #(
   parameter int unsigned LOW_LIMIT_US = 64,
   parameter int unsigned HOLD_US      = 120000,
   parameter int unsigned LCW          = shclk_wd_pkg::cnt_width(LOW_LIMIT_US),
   parameter int unsigned HCW          = shclk_wd_pkg::cnt_width(HOLD_US - 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tick_1us,
   input logic           clr_flag,
   input logic           line_s,
   input logic           detect,
   input logic [LCW-1:0] low_cnt,
   input logic [HCW-1:0] hold_cnt,
   input logic           pull_low,
   input logic           stuck_flag
);

   AST_RISE_AFTER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_low) |-> $past(low_cnt) == LCW'(LOW_LIMIT_US)); // R2

   AST_HIGH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      line_s |=> low_cnt == '0); // R3

   AST_HOLD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt <= HCW'(HOLD_US - 1)); // R4

   AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_low) |-> stuck_flag); // R5

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_flag && !detect) |=> !stuck_flag); // R6

   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_low) |=> !pull_low); // R7

   AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_1us |=> ($stable(low_cnt) || low_cnt == '0)); // R8

endmodule

bind shclk_stuck_watchdog shclk_wd_checker #(
   .LOW_LIMIT_US (LOW_LIMIT_US),
   .HOLD_US      (HOLD_US),
   .LCW          (LCW),
   .HCW          (HCW)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_1us   (tick_1us),
   .clr_flag   (clr_flag),
   .line_s     (line_s),
   .detect     (detect),
   .low_cnt    (low_cnt),
   .hold_cnt   (hold_cnt),
   .pull_low   (pull_low),
   .stuck_flag (stuck_flag)
);

// File: tb/shclk_stuck_watchdog_tb.sv
module shclk_stuck_watchdog_tb_top;

   localparam int unsigned LIM  = 8;
   localparam int unsigned HOLD = 20;
   localparam int VEC_N = 6;
   localparam int VLEN [VEC_N] = '{1, 3, 8, 9, 14, 30};
   localparam int VEXP [VEC_N] = '{0, 0, 0, 1, 1, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1us = 1'b1;
   logic clr_flag = 1'b0;
   logic ext_low = 1'b0;
   logic line_in;
   logic pull_low;
   logic stuck_flag;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign line_in = ~(ext_low | pull_low);

   shclk_stuck_watchdog #(
      .SYNC_STAGES  (2),
      .LOW_LIMIT_US (LIM),
      .HOLD_US      (HOLD),
      .SET_WINS     (1'b1)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_1us   (tick_1us),
      .line_in    (line_in),
      .clr_flag   (clr_flag),
      .pull_low   (pull_low),
      .stuck_flag (stuck_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clear();
      clr_flag = 1'b1;
      @(negedge clk);
      clr_flag = 1'b0;
      @(negedge clk);
   endtask

   task automatic ext_pulse(input int n);
      ext_low = 1'b1;
      cycles(n);
      ext_low = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hold_seen;
      cycles(3);
      check("R1 pull_low in reset", int'(pull_low), 0);
      check("R1 flag in reset", int'(stuck_flag), 0);
      rst_n = 1'b1;
      cycles(3);
      check("R1 pull_low after reset", int'(pull_low), 0);
      check("R1 flag after reset", int'(stuck_flag), 0);

      // R2 / R5 / R6 table walk: low length versus fault
      for (int v = 0; v < VEC_N; v++) begin
         ext_pulse(VLEN[v]);
         cycles(HOLD + LIM + 10);
         check($sformatf("R2 R5 flag after low of %0d", VLEN[v]), int'(stuck_flag), VEXP[v]);
         check("R4 pull_low released", int'(pull_low), 0);
         pulse_clear();
         check("R6 flag cleared", int'(stuck_flag), 0);
      end

      // R2 exact detection edge and R4 hold length
      ext_low = 1'b1;
      cycles(LIM + 2);
      check("R2 no drive before limit edge", int'(pull_low), 0);
      cycles(1);
      check("R2 drive at limit edge", int'(pull_low), 1);
      ext_low = 1'b0;
      hold_seen = 1;
      for (int i = 0; i < 4 * HOLD && pull_low; i++) begin
         cycles(1);
         if (pull_low) hold_seen++;
      end
      check("R4 hold length", hold_seen, HOLD);
      check("R5 flag kept after hold", int'(stuck_flag), 1);
      cycles(3 * LIM);
      check("R7 no retrigger after own hold", int'(pull_low), 0);
      pulse_clear();

      // R7 line kept low by another device after release; R6 clear in hold
      ext_low = 1'b1;
      cycles(LIM + 3);
      check("R7 detect again", int'(pull_low), 1);
      clr_flag = 1'b1;
      cycles(1);
      clr_flag = 1'b0;
      check("R6 clear does not end hold", int'(pull_low), 1);
      check("R6 clear drops flag in hold", int'(stuck_flag), 0);
      cycles(HOLD + 3 * LIM);
      check("R7 no detect while line still low", int'(pull_low), 0);
      check("R7 flag stays clear", int'(stuck_flag), 0);
      ext_low = 1'b0;
      cycles(5);
      ext_low = 1'b1;
      cycles(LIM + 3);
      check("R7 monitoring resumes after high", int'(pull_low), 1);
      ext_low = 1'b0;
      cycles(HOLD + 10);
      pulse_clear();

      // R3 one high sample resets the count
      ext_pulse(LIM);
      ext_pulse(0);
      cycles(1);
      ext_pulse(LIM);
      cycles(HOLD + 10);
      check("R3 split lows give no fault", int'(stuck_flag), 0);
      check("R3 no drive", int'(pull_low), 0);

      // R8 no ticks means no counting
      tick_1us = 1'b0;
      ext_low = 1'b1;
      cycles(4 * LIM);
      check("R8 no fault without ticks", int'(pull_low), 0);
      tick_1us = 1'b1;
      cycles(LIM);
      check("R8 still below limit", int'(pull_low), 0);
      cycles(1);
      check("R8 fault once ticks resume", int'(pull_low), 1);
      ext_low = 1'b0;
      cycles(HOLD + 10);
      check("R4 released after tick test", int'(pull_low), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule